// File: doc/BRIEF.md
# HDLC Receive Frame Status Engine

This block is the back end of a bit-serial HDLC receiver. An upstream stage has already found flags and removed stuffing zeros. It hands this block one beat per line bit. Each beat is one of three kinds: a data bit, a removed stuffing zero (marked, carries no data), or a whole flag (one beat stands for the eight flag bits). The engine builds octets least significant bit first and runs a frame check over every data bit. At the end of each frame it classifies the frame and issues a one-cycle close strobe with three status bits and an optional interrupt pulse. Every received octet, including the check field, leaves on a byte stream.

A frame ends on a flag or on an abort, which is seven consecutive data one-bits. The result is judged in a fixed order: abort, then non-octet length, then CRC or too-short. An abort suppresses the other two checks, and a non-octet frame suppresses the CRC check. After an abort the engine hunts: it discards bits until the next flag. A frame that ends in error on a flag still lets the frame that follows that same flag be received, so back-to-back frames are not lost. Two saturating counters track aborts and CRC failures, and the counters have a synchronous clear.

The input and output streams are valid/ready. A byte on `m_data` stays stable with `m_valid` high until `m_ready` takes it. While a byte is held, `s_ready` is low, so upstream bits stall instead of being dropped. Because of this, a close strobe is never issued while an earlier byte of the same frame is still waiting.

Top module: `hdlc_rx_status`

## Requirements
- R1: Data bits are packed least significant bit first. A full octet appears on `m_data` with `m_valid` high in the cycle after the edge that accepted its eighth data bit.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` stay stable and `s_ready` is low. No byte is lost or duplicated under back-pressure.
- R3: A frame that ends on a flag with a good check closes with `close_status` = 3'b000. `close_stb` is high in the cycle after the edge that accepted the flag beat. `close_status` has at most one bit set and is zero when no close occurs.
- R4: A seventh consecutive data one-bit inside a frame closes the frame at once with status bit 2 (abort) set and adds one to `abort_cnt`. The CRC counter is not touched. Bits are then discarded until a flag arrives.
- R5: A frame that ends on a flag after a number of data bits that is not a multiple of eight closes with status bit 1 (non-octet) set. The CRC result is ignored. The leftover k bits are emitted as one byte in the same cycle as the close, in positions 7 down to 8-k, with the earliest bit lowest, and zeros below.
- R6: A whole-octet frame whose check fails closes with status bit 0 (CRC) set and adds one to `crc_err_cnt`. All received octets, including the check bytes, are on the stream.
- R7: `crc_sel` is sampled at the first data bit of a frame. 2'b00 selects the 16-bit check (x^16+x^12+x^5+1, reflected, preset all ones). 2'b10 selects the 32-bit Ethernet check. The reserved codes 2'b01 and 2'b11 behave as 2'b00.
- R8: A whole-octet frame with fewer octets than the check length plus one closes with status bit 0 set and adds one to `crc_err_cnt`.
- R9: `irq` pulses with `close_stb` when `irq_en` was high at the closing edge. It is never high otherwise.
- R10: Both counters saturate at all ones. `cnt_clr` sets them to zero at the next edge and takes priority over an increment.
- R11: After reset the engine hunts: data bits before the first flag produce no byte and no close. Beats marked `s_drop` carry no data and break a run of ones.
- R12: The flag that closes an errored frame also opens the next frame, so a frame that follows it with no further flag is received and classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_sel | input | 2 | Check selection, sampled at frame start |
| irq_en | input | 1 | Interrupt enable |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_bit | input | 1 | Data bit value |
| s_drop | input | 1 | Beat is a removed stuffing zero |
| s_flag | input | 1 | Beat is a complete flag |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Sink accepts the byte |
| m_data | output | 8 | Received octet or partial octet |
| close_stb | output | 1 | One-cycle frame close strobe |
| close_status | output | 3 | Bit 2 abort, bit 1 non-octet, bit 0 CRC |
| irq | output | 1 | Receive-frame interrupt pulse |
| abort_cnt | output | CNT_W | Saturating abort counter |
| crc_err_cnt | output | CNT_W | Saturating CRC error counter |

## Verification
Every result is registered once. A completed octet is due one cycle after the edge that accepted its eighth bit. The close strobe, status, interrupt and counter update are due one cycle after the edge that accepted the flag beat or the seventh one. A non-octet leftover byte comes out in that same close cycle. The bench drives beats on falling edges and notes the cycle in which each beat was accepted. It samples outputs on falling edges and requires each close to carry the cycle number of the accepting edge. Counters and byte lists are compared only after a few idle cycles, once all due results have landed.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FRAME = 2'd2
  } rx_state_e;

  // close_status bit positions
  localparam int STAT_CRC  = 0;
  localparam int STAT_NOCT = 1;
  localparam int STAT_ABT  = 2;
  localparam int STAT_W    = 3;

  localparam int OCTET_W   = 8;
  localparam int ABORT_RUN = 7;
  localparam int NUM_CRC   = 2;
  localparam logic [1:0] SEL_CRC32 = 2'b10;

  function automatic int crc_width(input int k);
    return (k == 0) ? 16 : 32;
  endfunction

  function automatic logic [31:0] crc_poly(input int k);
    return (k == 0) ? 32'h0000_8408 : 32'hEDB8_8320;
  endfunction

  function automatic logic [31:0] crc_init(input int k);
    return (k == 0) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] crc_resid(input int k);
    return (k == 0) ? 32'h0000_F0B8 : 32'hDEBB_20E3;
  endfunction

endpackage

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int unsigned   W     = 16,
  parameter logic [W-1:0]  POLY  = '0,
  parameter logic [W-1:0]  INIT  = '1,
  parameter logic [W-1:0]  RESID = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en,
  input  logic din,
  output logic match
);

  logic [W-1:0] reg_q;
  logic [W-1:0] base;
  logic [W-1:0] nxt;
  logic         fb;

  // Reflected serial division; the whole frame including the check
  // field leaves a fixed residue when it is intact.
  always_comb begin
    base = start ? INIT : reg_q;
    fb   = base[0] ^ din;
    nxt  = (base >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  reg_q <= INIT;
    else if (en) reg_q <= nxt;
  end

  assign match = (reg_q == RESID);

endmodule

// File: rtl/hdlc_rx_sat_cnt.sv
module hdlc_rx_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)         q <= '0;
    else if (inc && (q != '1)) q <= q + 1'b1;
  end

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          crc_sel,
  input  logic                irq_en,
  input  logic                cnt_clr,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic                s_bit,
  input  logic                s_drop,
  input  logic                s_flag,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [OCTET_W-1:0]  m_data,
  output logic                close_stb,
  output logic [STAT_W-1:0]   close_status,
  output logic                irq,
  output logic [CNT_W-1:0]    abort_cnt,
  output logic [CNT_W-1:0]    crc_err_cnt
);

  localparam int POS_W = $clog2(OCTET_W);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);
  localparam int NB_W  = 3;
  localparam logic [NB_W-1:0] MIN_OCT16 = NB_W'(crc_width(0) / OCTET_W + 1);
  localparam logic [NB_W-1:0] MIN_OCT32 = NB_W'(crc_width(1) / OCTET_W + 1);

  rx_state_e            state;
  logic [RUN_W-1:0]     ones_run;
  logic [OCTET_W-1:0]   shreg;
  logic [POS_W-1:0]     bitpos;
  logic [NB_W-1:0]      nbytes;
  logic                 use32;

  logic                 accept, data_beat, seventh_one;
  logic                 in_frame, frame_start, crc_en;
  logic                 fr_abort, fr_end, nonoct, too_short, crc_ok;
  logic                 close_n;
  logic [STAT_W-1:0]    status_n;
  logic [NUM_CRC-1:0]   crc_match;
  logic [OCTET_W-1:0]   shifted;

  assign s_ready     = !m_valid;
  assign accept      = s_valid && s_ready;
  assign data_beat   = accept && !s_drop && !s_flag;
  assign seventh_one = data_beat && s_bit && (ones_run == RUN_W'(ABORT_RUN - 1));
  assign in_frame    = (state == ST_FRAME);
  assign frame_start = (state == ST_IDLE) && data_beat;
  assign crc_en      = data_beat && (state != ST_HUNT);
  assign shifted     = {s_bit, shreg[OCTET_W-1:1]};

  // One serial checker per supported polynomial
  for (genvar g = 0; g < NUM_CRC; g++) begin : g_crc
    localparam int GW = crc_width(g);
    hdlc_rx_crc #(
      .W    (GW),
      .POLY (GW'(crc_poly(g))),
      .INIT (GW'(crc_init(g))),
      .RESID(GW'(crc_resid(g)))
    ) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .start(frame_start),
      .en   (crc_en),
      .din  (s_bit),
      .match(crc_match[g])
    );
  end

  // Classification, fixed precedence: abort > non-octet > check
  always_comb begin
    fr_abort  = in_frame && seventh_one;
    fr_end    = in_frame && accept && s_flag;
    nonoct    = (bitpos != '0);
    too_short = nbytes < (use32 ? MIN_OCT32 : MIN_OCT16);
    crc_ok    = use32 ? crc_match[1] : crc_match[0];
    close_n   = fr_abort || fr_end;
    status_n  = '0;
    if (fr_abort)                     status_n[STAT_ABT]  = 1'b1;
    else if (fr_end && nonoct)        status_n[STAT_NOCT] = 1'b1;
    else if (fr_end && (too_short || !crc_ok)) status_n[STAT_CRC] = 1'b1;
  end

  hdlc_rx_sat_cnt #(.W(CNT_W)) u_abort_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (status_n[STAT_ABT]),
    .q    (abort_cnt)
  );

  hdlc_rx_sat_cnt #(.W(CNT_W)) u_crc_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (status_n[STAT_CRC]),
    .q    (crc_err_cnt)
  );

  // Run of consecutive data ones; any other accepted beat breaks it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_run <= '0;
    end else if (accept) begin
      if (data_beat && s_bit) begin
        if (ones_run != RUN_W'(ABORT_RUN)) ones_run <= ones_run + 1'b1;
      end else begin
        ones_run <= '0;
      end
    end
  end

  // Frame state and octet assembly
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      shreg  <= '0;
      bitpos <= '0;
      nbytes <= '0;
      use32  <= 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (accept && s_flag) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (frame_start) begin
            state  <= ST_FRAME;
            shreg  <= {s_bit, {(OCTET_W-1){1'b0}}};
            bitpos <= POS_W'(1);
            nbytes <= '0;
            use32  <= (crc_sel == SEL_CRC32);
          end
        end
        ST_FRAME: begin
          if (fr_abort) begin
            state <= ST_HUNT;
          end else if (fr_end) begin
            state <= ST_IDLE;
          end else if (data_beat) begin
            bitpos <= bitpos + 1'b1;
            if (bitpos == POS_W'(OCTET_W - 1)) begin
              shreg <= '0;
              if (nbytes != '1) nbytes <= nbytes + 1'b1;
            end else begin
              shreg <= shifted;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // Output byte register and close signalling
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid      <= 1'b0;
      m_data       <= '0;
      close_stb    <= 1'b0;
      close_status <= '0;
      irq          <= 1'b0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (in_frame && data_beat && !seventh_one &&
          (bitpos == POS_W'(OCTET_W - 1))) begin
        m_valid <= 1'b1;
        m_data  <= shifted;
      end else if (fr_end && nonoct) begin
        m_valid <= 1'b1;
        m_data  <= shreg;
      end
      close_stb    <= close_n;
      close_status <= status_n;
      irq          <= close_n && irq_en;
    end
  end

endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             cnt_clr,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             close_stb,
  input logic [2:0]       close_status,
  input logic             irq,
  input logic [CNT_W-1:0] abort_cnt,
  input logic [CNT_W-1:0] crc_err_cnt
);

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    close_stb |-> $onehot0(close_status)); // R3

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !close_stb |-> (close_status == 3'b000)); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (close_stb && $past(irq_en))); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R2

  AST_NO_INTAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R2

  AST_ABORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((abort_cnt == $past(abort_cnt)) ||
                  (abort_cnt == $past(abort_cnt) + 1'b1))); // R4

  AST_ABORT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (close_stb && close_status[2] && !$past(cnt_clr) && ($past(abort_cnt) != '1))
      |-> (abort_cnt == $past(abort_cnt) + 1'b1)); // R4

  AST_CRC_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (close_stb && close_status[0] && !$past(cnt_clr) && ($past(crc_err_cnt) != '1))
      |-> (crc_err_cnt == $past(crc_err_cnt) + 1'b1)); // R6

  AST_ABORT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((abort_cnt == '1) && !cnt_clr) |=> (abort_cnt == '1)); // R10

  AST_CRC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((crc_err_cnt == '1) && !cnt_clr) |=> (crc_err_cnt == '1)); // R10

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> ((abort_cnt == '0) && (crc_err_cnt == '0))); // R10

endmodule

bind hdlc_rx_status hdlc_rx_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_en      (irq_en),
  .cnt_clr     (cnt_clr),
  .s_ready     (s_ready),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .close_stb   (close_stb),
  .close_status(close_status),
  .irq         (irq),
  .abort_cnt   (abort_cnt),
  .crc_err_cnt (crc_err_cnt)
);

// File: tb/hdlc_rx_status_tb.sv
module hdlc_rx_status_tb;

  localparam int CW = 4;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    crc_sel = 2'b00;
  logic          irq_en = 1'b1;
  logic          cnt_clr = 1'b0;
  logic          s_valid = 1'b0, s_bit = 1'b0, s_drop = 1'b0, s_flag = 1'b0;
  logic          s_ready;
  logic          m_valid, m_ready = 1'b1;
  logic [7:0]    m_data;
  logic          close_stb, irq;
  logic [2:0]    close_status;
  logic [CW-1:0] abort_cnt, crc_err_cnt;

  hdlc_rx_status #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .crc_sel(crc_sel), .irq_en(irq_en),
    .cnt_clr(cnt_clr), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .s_drop(s_drop), .s_flag(s_flag), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .close_stb(close_stb), .close_status(close_status),
    .irq(irq), .abort_cnt(abort_cnt), .crc_err_cnt(crc_err_cnt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  int last_acc = 0;
  int ones_tx = 0;
  int stray_irq = 0;
  int hold_viol = 0;
  bit done = 1'b0;

  logic [7:0] rx_bytes[$];
  logic [2:0] rx_stat[$];
  int         rx_cyc[$];
  logic       rx_irq[$];

  // Output monitor on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready) rx_bytes.push_back(m_data);
      if (m_valid && s_ready) hold_viol++;
      if (close_stb) begin
        rx_stat.push_back(close_status);
        rx_cyc.push_back(cyc);
        rx_irq.push_back(irq);
      end else if (irq) begin
        stray_irq++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic beat(input logic b, input logic d, input logic f);
    @(negedge clk);
    s_valid = 1'b1; s_bit = b; s_drop = d; s_flag = f;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    last_acc = cyc;
    s_valid = 1'b0;
  endtask

  task automatic tx_bit(input logic b);
    if (b) begin
      beat(1'b1, 1'b0, 1'b0);
      ones_tx++;
      if (ones_tx == 5) begin
        beat(1'b0, 1'b1, 1'b0);
        ones_tx = 0;
      end
    end else begin
      beat(1'b0, 1'b0, 1'b0);
      ones_tx = 0;
    end
  endtask

  task automatic tx_flag();
    beat(1'b0, 1'b0, 1'b1);
    ones_tx = 0;
  endtask

  task automatic tx_bytes(input bq_t q);
    foreach (q[i]) for (int j = 0; j < 8; j++) tx_bit(q[i][j]);
  endtask

  function automatic bq_t with_fcs(input bq_t p, input bit w32, input bit bad);
    logic [31:0] c, poly;
    bq_t r;
    int nb;
    logic fb;
    c    = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = w32 ? 32'hEDB8_8320 : 32'h0000_8408;
    nb   = w32 ? 4 : 2;
    r    = p;
    foreach (p[i]) for (int j = 0; j < 8; j++) begin
      fb = c[0] ^ p[i][j];
      c  = c >> 1;
      if (fb) c = c ^ poly;
    end
    c = ~c;
    for (int k = 0; k < nb; k++) r.push_back(c[8*k +: 8]);
    if (bad) r[r.size()-1] = r[r.size()-1] ^ 8'h01;
    return r;
  endfunction

  task automatic clear_rx();
    rx_bytes.delete(); rx_stat.delete(); rx_cyc.delete(); rx_irq.delete();
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_bytes(input bq_t e, input string rq);
    int bad = 0;
    chk(rx_bytes.size() == e.size(), {rq, " byte count"}, rx_bytes.size(), e.size());
    if (rx_bytes.size() == e.size())
      foreach (e[i]) if (rx_bytes[i] !== e[i]) bad++;
    chk(bad == 0, {rq, " byte values"}, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!m_valid && !close_stb && !irq && s_ready, "reset outputs", {m_valid, close_stb, irq, s_ready}, 4'b0001);
    chk(abort_cnt == 0 && crc_err_cnt == 0, "reset counters", {abort_cnt, crc_err_cnt}, 0);
  endtask

  task automatic t_hunt_good();
    bq_t p, e;
    clear_rx();
    crc_sel = 2'b00;
    beat(1,0,0); beat(0,0,0); beat(1,0,0); beat(1,0,0); beat(0,0,0); beat(1,0,0);
    settle();
    chk(rx_bytes.size() == 0 && rx_stat.size() == 0, "R11 hunt discards", rx_bytes.size() + rx_stat.size(), 0);
    p = '{8'hFF, 8'h7E, 8'h3C};
    e = with_fcs(p, 1'b0, 1'b0);
    tx_flag(); tx_bytes(e); tx_flag();
    settle();
    chk_bytes(e, "R1 R11 lsb-first with stuffing");
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b000, "R3 good status", rx_stat.size() ? rx_stat[0] : 7, 0);
    chk(rx_cyc.size() == 1 && rx_cyc[0] == last_acc, "R3 close timing", rx_cyc.size() ? rx_cyc[0] : -1, last_acc);
    chk(rx_irq.size() == 1 && rx_irq[0] == 1'b1, "R9 irq with close", rx_irq.size() ? rx_irq[0] : 0, 1);
  endtask

  task automatic t_crc_select();
    bq_t p, e;
    clear_rx();
    p = '{8'h01, 8'h02, 8'h03, 8'h04, 8'hA5};
    crc_sel = 2'b10;
    e = with_fcs(p, 1'b1, 1'b0);
    tx_flag(); tx_bytes(e); tx_flag();
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b000, "R7 32-bit good", rx_stat.size() ? rx_stat[0] : 7, 0);
    chk_bytes(e, "R7 32-bit bytes");
    clear_rx();
    e = with_fcs(p, 1'b0, 1'b0);
    tx_bytes(e); tx_flag();
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b001, "R7 16-bit field under 32 select", rx_stat.size() ? rx_stat[0] : 7, 1);
    clear_rx();
    crc_sel = 2'b01;
    tx_bytes(e); tx_flag();
    crc_sel = 2'b00;
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b000, "R7 reserved code acts as 16-bit", rx_stat.size() ? rx_stat[0] : 7, 0);
  endtask

  task automatic t_crc_err_b2b();
    bq_t p, e1, e2, all;
    int c0;
    clear_rx();
    crc_sel = 2'b00;
    c0 = crc_err_cnt;
    p  = '{8'h55, 8'hC3, 8'h81, 8'h00};
    e1 = with_fcs(p, 1'b0, 1'b1);
    e2 = with_fcs(p, 1'b0, 1'b0);
    tx_flag(); tx_bytes(e1); tx_flag(); tx_bytes(e2); tx_flag();
    settle();
    chk(rx_stat.size() == 2 && rx_stat[0] == 3'b001, "R6 crc status", rx_stat.size() ? rx_stat[0] : 7, 1);
    chk(rx_stat.size() == 2 && rx_stat[1] == 3'b000, "R12 back-to-back after error", rx_stat.size() > 1 ? rx_stat[1] : 7, 0);
    chk(crc_err_cnt == c0 + 1, "R6 crc counter", crc_err_cnt, c0 + 1);
    all = e1;
    foreach (e2[i]) all.push_back(e2[i]);
    chk_bytes(all, "R6 check bytes streamed");
  endtask

  task automatic t_nonoct();
    bq_t p, e;
    int c0;
    clear_rx();
    c0 = crc_err_cnt;
    p = '{8'h9A, 8'h11, 8'hE0};
    e = with_fcs(p, 1'b0, 1'b0);
    tx_flag(); tx_bytes(e);
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    tx_flag();
    settle();
    e.push_back(8'hA0);
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b010, "R5 non-octet status only", rx_stat.size() ? rx_stat[0] : 7, 2);
    chk_bytes(e, "R5 partial byte");
    chk(crc_err_cnt == c0, "R5 crc not counted", crc_err_cnt, c0);
  endtask

  task automatic t_abort();
    bq_t p, e, all;
    int a0, c0, abt_cyc;
    clear_rx();
    a0 = abort_cnt; c0 = crc_err_cnt;
    tx_flag(); tx_bytes('{8'h12});
    for (int i = 0; i < 7; i++) beat(1'b1, 1'b0, 1'b0);
    abt_cyc = last_acc;
    ones_tx = 0;
    beat(0,0,0); beat(1,0,0); beat(1,0,0); beat(0,0,0); beat(1,0,0);
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b100, "R4 abort status", rx_stat.size() ? rx_stat[0] : 7, 4);
    chk(rx_cyc.size() == 1 && rx_cyc[0] == abt_cyc, "R4 abort timing", rx_cyc.size() ? rx_cyc[0] : -1, abt_cyc);
    chk(abort_cnt == a0 + 1 && crc_err_cnt == c0, "R4 counters", {abort_cnt, crc_err_cnt}, {4'(a0 + 1), 4'(c0)});
    chk_bytes('{8'h12}, "R4 hunt discards after abort");
    clear_rx();
    p = '{8'h42, 8'h24, 8'h99};
    e = with_fcs(p, 1'b0, 1'b0);
    tx_flag(); tx_bytes(e); tx_flag();
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b000, "R4 recovery after flag", rx_stat.size() ? rx_stat[0] : 7, 0);
  endtask

  task automatic t_short();
    int c0;
    clear_rx();
    c0 = crc_err_cnt;
    tx_flag(); tx_bytes('{8'h0F, 8'hB8}); tx_flag();
    settle();
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b001, "R8 short frame status", rx_stat.size() ? rx_stat[0] : 7, 1);
    chk(crc_err_cnt == c0 + 1, "R8 short frame counted", crc_err_cnt, c0 + 1);
  endtask

  task automatic t_backpressure();
    bq_t p, e;
    clear_rx();
    hold_viol = 0;
    p = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00, 8'hFF};
    e = with_fcs(p, 1'b0, 1'b0);
    fork
      begin tx_flag(); tx_bytes(e); tx_flag(); end
      begin
        for (int i = 0; i < 300; i++) begin
          @(posedge clk); #2;
          m_ready = (i % 5 == 4);
        end
        m_ready = 1'b1;
      end
    join
    settle();
    chk_bytes(e, "R2 no loss under stall");
    chk(hold_viol == 0, "R2 input held off", hold_viol, 0);
    chk(rx_stat.size() == 1 && rx_stat[0] == 3'b000, "R2 frame intact", rx_stat.size() ? rx_stat[0] : 7, 0);
  endtask

  task automatic t_irq_mask();
    clear_rx();
    irq_en = 1'b0;
    tx_flag(); tx_bytes(with_fcs('{8'h77, 8'h66}, 1'b0, 1'b0)); tx_flag();
    settle();
    irq_en = 1'b1;
    chk(rx_irq.size() == 1 && rx_irq[0] == 1'b0, "R9 masked irq", rx_irq.size() ? rx_irq[0] : 1, 0);
    chk(stray_irq == 0, "R9 no irq without close", stray_irq, 0);
  endtask

  task automatic t_saturate();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk(abort_cnt == 0 && crc_err_cnt == 0, "R10 clear", {abort_cnt, crc_err_cnt}, 0);
    for (int n = 0; n < 17; n++) begin
      tx_flag();
      for (int i = 0; i < 7; i++) beat(1'b1, 1'b0, 1'b0);
    end
    settle();
    chk(abort_cnt == 4'hF, "R10 saturate", abort_cnt, 4'hF);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk(abort_cnt == 0, "R10 clear after saturate", abort_cnt, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hunt_good();
    t_crc_select();
    t_crc_err_b2b();
    t_nonoct();
    t_abort();
    t_short();
    t_backpressure();
    t_irq_mask();
    t_saturate();
    finish_run();
  end

endmodule